// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block cleans up a bank of already synchronized GPIO input levels before they reach an interrupt detector. Every pin can be left unfiltered, filtered at the full clock rate, or filtered at a slow sampling rate set by one shared programmable divider. A filtered pin takes a new level only once the input has been seen at that level on two sampling points in a row. That gives a rejection window of roughly two sampling periods, which the divider can stretch to a long time.

Software configures the block through three write-only configuration words. Each word is reached as two half-word addresses. On every write, bits 31:16 are a per-bit write mask and bits 15:0 are the data, so one pin's setting can change without a read-modify-write. The whole design runs on one clock. The divider gives a one-cycle sampling tick rather than a second clock.

Top module: `gpio_debounce`

## Requirements
- R1: While reset is asserted and right after it is released, every pin is unfiltered, so `pin_filt` equals `pin_sync`. The divider value clears to 0.
- R2: A write updates only the register bits whose mask bit `wr_data[16+k]` is 1, loading them from `wr_data[k]`. Address 0x00 holds filter enables for pins 15:0 and 0x04 holds them for pins 31:16. Address 0x08 and 0x0C hold the slow-sampling selects the same way. Address 0x10 holds divider bits 15:0 and 0x14 holds divider bits 23:16 in data bits 7:0. A write with an all-zero mask changes nothing.
- R3: A pin whose filter enable is 0 drives `pin_filt` from `pin_sync` combinationally, in the same cycle.
- R4: A filtered pin changes its output only after two consecutive samples agree with each other and differ from the present output. On a pin sampling every clock, a held input change shows on `pin_filt` two clock edges after it is applied.
- R5: On a pin sampling every clock, a pulse lasting one clock never reaches `pin_filt`.
- R6: The divider gives a one-cycle tick every D+1 clocks, where D is the divider value. Any write to address 0x10 or 0x14 restarts the count, even with a zero mask. The first tick sampling edge comes D+1 edges after the write edge.
- R7: A filtered pin with its slow select at 1 samples only on tick edges. It ignores input activity between ticks and needs the same new level on two consecutive ticks.
- R8: A filtered pin with its slow select at 1 behaves like a full-rate pin while the divider value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers, divider and filters |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe, one write per cycle |
| wr_addr | input | 8 | Byte address of the half-word being written |
| wr_data | input | 32 | Mask in bits 31:16, data in bits 15:0 |
| pin_sync | input | NPINS | Synchronized pin levels |
| pin_filt | output | NPINS | Debounced pin levels |

## Verification
The assertions assume that `pin_sync` has already passed through a synchronizer, so it holds one clean value per clock. They also assume that configuration writes change the enables only between sampling decisions, never as part of a stable-level argument. The stimulus changes pins and write signals only on the falling edge. It lets every pin settle with its filter enabled before switching it to slow sampling, and it places each slow-mode pulse relative to the known reload edge of the divider, so every expected edge follows from the written divider value.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
    // Half-word write convention: mask in the upper half, data in the lower half
    localparam int HALF_W = 16;
    localparam int NHALF  = 2;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_EN_LO   = 8'h00;
    localparam logic [ADDR_W-1:0] A_EN_HI   = 8'h04;
    localparam logic [ADDR_W-1:0] A_SLOW_LO = 8'h08;
    localparam logic [ADDR_W-1:0] A_SLOW_HI = 8'h0C;
    localparam logic [ADDR_W-1:0] A_DIV_LO  = 8'h10;
    localparam logic [ADDR_W-1:0] A_DIV_HI  = 8'h14;

    // Per-pin filter state: accepted level and last sample taken
    typedef struct packed {
        logic level;
        logic prev;
    } flt_t;
endpackage

// File: rtl/gdb_regs.sv
module gdb_regs
    import gdb_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DIV_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [2*HALF_W-1:0]    wr_data,
    output logic [NPINS-1:0]       cfg_en,
    output logic [NPINS-1:0]       cfg_slow,
    output logic [DIV_W-1:0]       div_val,
    output logic [DIV_W-1:0]       div_next,
    output logic                   div_load
);
    typedef struct packed {
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] slow;
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [NHALF-1:0] hit_en, hit_slow, hit_div;

    always_comb begin
        cfg_d    = cfg_q;
        hit_en   = '0;
        hit_slow = '0;
        hit_div  = '0;
        if (wr_en) begin
            case (wr_addr)
                A_EN_LO:   hit_en[0]   = 1'b1;
                A_EN_HI:   hit_en[1]   = 1'b1;
                A_SLOW_LO: hit_slow[0] = 1'b1;
                A_SLOW_HI: hit_slow[1] = 1'b1;
                A_DIV_LO:  hit_div[0]  = 1'b1;
                A_DIV_HI:  hit_div[1]  = 1'b1;
                default:   ;
            endcase
        end
        div_load = |hit_div;
        for (int b = 0; b < NPINS; b++) begin
            if (hit_en[b / HALF_W] && wr_data[HALF_W + (b % HALF_W)])
                cfg_d.en[b] = wr_data[b % HALF_W];
            if (hit_slow[b / HALF_W] && wr_data[HALF_W + (b % HALF_W)])
                cfg_d.slow[b] = wr_data[b % HALF_W];
        end
        for (int b = 0; b < DIV_W; b++) begin
            if (hit_div[b / HALF_W] && wr_data[HALF_W + (b % HALF_W)])
                cfg_d.div[b] = wr_data[b % HALF_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_en   = cfg_q.en;
    assign cfg_slow = cfg_q.slow;
    assign div_val  = cfg_q.div;
    assign div_next = cfg_d.div;
endmodule

// File: rtl/gdb_divider.sv
module gdb_divider #(
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = (cnt_q == '0);
        if (load)      cnt_d = load_val;
        else if (tick) cnt_d = div_val;
        else           cnt_d = cnt_q - DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/gdb_filter.sv
module gdb_filter
    import gdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic en,
    input  logic samp_en,
    output logic dout
);
    flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            // track the input so enabling never causes a step
            st_d.level = din;
            st_d.prev  = din;
        end else if (samp_en) begin
            st_d.prev = din;
            if (din == st_q.prev && din != st_q.level)
                st_d.level = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = en ? st_q.level : din;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
    import gdb_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DIV_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [2*HALF_W-1:0] wr_data,
    input  logic [NPINS-1:0]    pin_sync,
    output logic [NPINS-1:0]    pin_filt
);
    logic [NPINS-1:0] cfg_en, cfg_slow;
    logic [DIV_W-1:0] div_val, div_next;
    logic             div_load, div_tick;

    gdb_regs #(.NPINS(NPINS), .DIV_W(DIV_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg_en   (cfg_en),
        .cfg_slow (cfg_slow),
        .div_val  (div_val),
        .div_next (div_next),
        .div_load (div_load)
    );

    gdb_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .load_val (div_next),
        .div_val  (div_val),
        .tick     (div_tick)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic samp_en;
        assign samp_en = cfg_slow[i] ? div_tick : 1'b1;
        gdb_filter u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (pin_sync[i]),
            .en      (cfg_en[i]),
            .samp_en (samp_en),
            .dout    (pin_filt[i])
        );
    end
endmodule

// File: rtl/gdb_checker.sv
module gdb_checker
    import gdb_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DIV_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [2*HALF_W-1:0] wr_data,
    input logic [NPINS-1:0]    pin_sync,
    input logic [NPINS-1:0]    pin_filt,
    input logic [NPINS-1:0]    en,
    input logic [NPINS-1:0]    slow,
    input logic [DIV_W-1:0]    div_val,
    input logic                tick,
    input logic                div_load
);
    // R2: a zero-mask write to the low enable half leaves the enables alone
    a_r2_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == A_EN_LO && wr_data[2*HALF_W-1:HALF_W] == '0 |=> $stable(en));

    // R6: after a tick with a nonzero divider and no reload, the next cycle has no tick
    a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick && div_val != '0 && !div_load |=> !tick);

    // R6: a reload restarts the count, so the next cycle ticks only for a zero divider
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |=> (tick == (div_val == '0)));

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        // R4: an enabled output moves only to a level seen on the two previous cycles
        a_r4_two_sample: assert property (@(posedge clk) disable iff (!rst_n)
            en[i] && $past(en[i]) && pin_filt[i] != $past(pin_filt[i])
            |-> $past(pin_sync[i]) == pin_filt[i] && $past(pin_sync[i], 2) == pin_filt[i]);

        // R7: a slow pin holds its output across an edge without a tick
        a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
            $past(en[i] && slow[i] && !tick) && en[i] |-> $stable(pin_filt[i]));
    end
endmodule

bind gpio_debounce gdb_checker #(.NPINS(NPINS), .DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pin_sync (pin_sync),
    .pin_filt (pin_filt),
    .en       (cfg_en),
    .slow     (cfg_slow),
    .div_val  (div_val),
    .tick     (div_tick),
    .div_load (div_load)
);

// File: tb/gpio_debounce_test.sv
`timescale 1ns/1ps
module gpio_debounce_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] pin_sync = 32'hA5A5_0F0F;
    logic [31:0] pin_filt;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          when;
        logic [31:0] m;
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t sb[$];

    gpio_debounce uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pin_sync (pin_sync),
        .pin_filt (pin_filt)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares scoreboard entries due in this cycle, after the edge settles
    initial begin
        forever begin
            @(posedge clk);
            #1;
            for (int k = 0; k < sb.size(); ) begin
                if (sb[k].when == cyc) begin
                    total++;
                    if ((pin_filt & sb[k].m) !== (sb[k].v & sb[k].m)) begin
                        bad++;
                        $display("FAIL %s: got %h expected %h (mask %h) cycle %0d",
                                 sb[k].tag, pin_filt & sb[k].m, sb[k].v & sb[k].m, sb[k].m, cyc);
                    end
                    sb.delete(k);
                end else begin
                    k++;
                end
            end
        end
    end

    task automatic push(input int k, input logic [31:0] m, input logic [31:0] v, input string tag);
        sb.push_back('{cyc + k, m, v, tag});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int c);
        while (cyc != c) @(negedge clk);
    endtask

    initial begin
        int w;
        int w2;
        idle(4);
        rst_n = 1'b1;
        // R1: all pins unfiltered after reset
        push(1, 32'hFFFF_FFFF, 32'hA5A5_0F0F, "R1 reset passthrough");
        idle(1);
        // R3: unfiltered pins follow the input in the same cycle
        pin_sync = 32'h1234_5678;
        push(1, 32'hFFFF_FFFF, 32'h1234_5678, "R3 bypass same cycle");
        idle(2);

        // R2: enable every pin at full rate via both halves
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        idle(3);

        // R5: one-clock pulse on pin 0 is rejected
        push(1, 32'h1, 32'h0, "R5 glitch pin0 +1");
        push(2, 32'h1, 32'h0, "R5 glitch pin0 +2");
        push(3, 32'h1, 32'h0, "R5 glitch pin0 +3");
        pin_sync[0] = 1'b1;
        idle(1);
        pin_sync[0] = 1'b0;
        idle(4);

        // R4: held change on pins 3 and 20 shows after two edges
        push(1, 32'h0010_0008, 32'h0010_0008, "R4 step old level");
        push(2, 32'h0010_0008, 32'h0000_0000, "R4 step new level");
        pin_sync[3] = 1'b0;
        pin_sync[20] = 1'b0;
        idle(4);

        // R2: masked write disables pin 0 only; zero-mask write does nothing
        wr(8'h00, 32'h0001_0000);
        wr(8'h00, 32'h0000_FFFF);
        idle(2);
        push(1, 32'h3, 32'h1, "R2 masked bit0 bypass, bit1 filtered");
        push(2, 32'h3, 32'h0, "R2 pulse ends");
        pin_sync[1:0] = 2'b11;
        idle(1);
        pin_sync[1:0] = 2'b00;
        idle(4);

        // R8: slow pins with divider 0 act at full rate
        wr(8'h08, 32'hFFFF_FFFF);
        idle(2);
        push(1, 32'h2, 32'h0, "R8 slow div0 old");
        push(2, 32'h2, 32'h2, "R8 slow div0 new");
        pin_sync[1] = 1'b1;
        idle(4);

        // R6/R7: divider 4, tick sampling edges at w+5, w+10, ...
        wr(8'h10, 32'hFFFF_0004);
        w = cyc;
        pin_sync[5] = 1'b0;
        push(9, 32'h20, 32'h20, "R7 slow step before second tick");
        push(10, 32'h20, 32'h00, "R6 slow step at second tick");
        wait_cyc(w + 10);
        // R7: pin 6 low for exactly one tick edge (w+15)
        pin_sync[6] = 1'b0;
        wait_cyc(w + 15);
        pin_sync[6] = 1'b1;
        // R7: pin 7 high only between ticks
        pin_sync[7] = 1'b1;
        push(2, 32'hC0, 32'h40, "R7 single tick pulse ignored +2");
        push(7, 32'hC0, 32'h40, "R7 between tick pulse ignored +7");
        wait_cyc(w + 18);
        pin_sync[7] = 1'b0;

        // R6: zero-mask write to the high divider half restarts the count, D stays 4
        wait_cyc(w + 22);
        wr(8'h14, 32'h0000_00FF);
        w2 = cyc;
        pin_sync[2] = 1'b1;
        push(9, 32'h4, 32'h0, "R6 reload phase old");
        push(10, 32'h4, 32'h4, "R6 reload phase new");
        idle(14);

        if (sb.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R1-summary: %0d checks never reached, expected 0", sb.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule